// File: doc/BRIEF.md
# Immediate Extension Prefix Decoder

This block sits in the decode stage of a 16-bit load-store processor with a four-stage pipeline. Some instruction words have only a short operand field, and some have none at all. A special prefix word can be placed in front of any instruction to give it a wide operand. The block spots the prefix word and keeps its 12 payload bits. When the next valid instruction arrives, it joins the payload with that instruction's own field, if it has one. The result is a 16-bit operand. The block also raises a flag that tells the datapath to use the extended form.

A prefixed load-immediate builds a full 16-bit constant. A prefixed register-indirect load gains a signed byte displacement in the range -2048 to +2047. A prefixed register-register add becomes a three-operand add, with a signed 12-bit immediate as the third operand. While a prefix is held, the block asks the interrupt logic to hold off, so that no interrupt can come between the prefix and the instruction it belongs to. A pipeline flush throws away any held prefix.

Each output appears one clock after the instruction word that produces it is sampled.

Top module: `imm_prefix_decoder`

## Requirements
- R1: While reset is high and on the first cycle after it, `op_valid_o`, `ext_o`, `irq_inhibit_o` and `operand_o` are all 0.
- R2: A valid word whose bits [15:12] are 4'hF is a prefix. Its bits [11:0] are the payload. A prefix yields no operand: `op_valid_o` is 0 on the following cycle. A word with that top nibble is ignored while `instr_valid_i` is low.
- R3: Load-immediate has opcode bits [15:12] = 4'h1 and a 4-bit field in bits [3:0]. Without a held prefix, the operand is that field zero-extended to 16 bits, and `ext_o` is 0.
- R4: Load-immediate with a held prefix gives the operand {payload, bits[3:0]}, and `ext_o` is 1.
- R5: Every other non-prefix opcode, such as 4'h2 (register-indirect load) and 4'h3 (register-register add), has a zero-width field. Without a held prefix, its operand is 0 and `ext_o` is 0.
- R6: A zero-width-field instruction with a held prefix gets the payload sign-extended from bit 11, covering -2048 to +2047, and `ext_o` is 1.
- R7: A held prefix is used up by the next valid non-prefix instruction, and by that instruction only. Cycles with `instr_valid_i` low in between do not drop the prefix. The instruction after the one that used the prefix is not extended.
- R8: A second prefix that arrives while one is held replaces the held payload.
- R9: When `flush_i` is high, any held prefix is discarded. The word presented in that cycle is ignored, so on the next cycle `op_valid_o` is 0 and `irq_inhibit_o` is 0.
- R10: `irq_inhibit_o` is 1 exactly on the cycles during which a prefix is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Fetched instruction word |
| instr_valid_i | input | 1 | Word on `instr_i` is valid this cycle |
| flush_i | input | 1 | Pipeline flush; discards the held prefix and the current word |
| op_valid_o | output | 1 | A non-prefix instruction was decoded last cycle |
| operand_o | output | 16 | Merged operand (0 when `op_valid_o` is low) |
| ext_o | output | 1 | Operand uses the extended form |
| irq_inhibit_o | output | 1 | A prefix is held; interrupts must wait |

## Verification
The hardest states to reach from the ports are those where a held prefix meets something other than its target. These cases are:
- a flush arriving in the same cycle as a new prefix;
- a second prefix replacing the first;
- a prefix waiting through several invalid cycles;
- a prefix-coded word presented with the valid flag low.

The stimulus sends prefixes back to back, and also with idle gaps of different lengths. It raises the flush both while a prefix is held and in the same cycle as a prefix. It uses payloads at both ends of the signed range (0x7FF, 0x800, 0xFFF). A behavioural model checks every output on every cycle, alongside directed checks of known operand values.

// File: rtl/imm_prefix_pkg.sv
package imm_prefix_pkg;

  // Kind of operand field carried natively by a decoded instruction
  typedef enum logic [1:0] {
    FLD_NONE  = 2'd0,  // zero-width field
    FLD_SHORT = 2'd1,  // short immediate in the low bits
    FLD_PFX   = 2'd2   // the word is itself a prefix
  } fld_kind_t;

endpackage

// File: rtl/imm_prefix_hold.sv
// Holds the payload of the most recent prefix until it is consumed or flushed.
module imm_prefix_hold #(
  parameter int PAY_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             accept,
  input  logic             is_pfx,
  input  logic [PAY_W-1:0] pay_in,
  output logic             held,
  output logic [PAY_W-1:0] pay
);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      held <= 1'b0;
      pay  <= '0;
    end else if (accept) begin
      if (is_pfx) begin
        held <= 1'b1;
        pay  <= pay_in;
      end else begin
        held <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/imm_prefix_merge.sv
// Combines the held payload with the native field of the current instruction.
module imm_prefix_merge
  import imm_prefix_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int PAY_W   = 12,
  parameter int SHORT_W = 4
) (
  input  fld_kind_t         kind,
  input  logic [WORD_W-1:0] word,
  input  logic              held,
  input  logic [PAY_W-1:0]  pay,
  output logic [WORD_W-1:0] operand
);

  localparam int SEXT_W = WORD_W - PAY_W;

  logic [WORD_W-1:0] none_op;
  logic [WORD_W-1:0] short_op;

  // Zero-width field: payload sign-extended when prefixed, otherwise zero
  assign none_op = held ? {{SEXT_W{pay[PAY_W-1]}}, pay} : '0;

  generate
    if (SHORT_W > 0) begin : g_short
      localparam int CAT_W = PAY_W + SHORT_W;
      logic [SHORT_W-1:0] fld;
      logic [CAT_W-1:0]   cat;
      assign fld = word[SHORT_W-1:0];
      assign cat = {pay, fld};
      assign short_op = held ? WORD_W'(cat)
                             : {{(WORD_W-SHORT_W){1'b0}}, fld};
    end else begin : g_noshort
      assign short_op = none_op;
    end
  endgenerate

  always_comb begin
    unique case (kind)
      FLD_SHORT: operand = short_op;
      FLD_NONE:  operand = none_op;
      default:   operand = '0;
    endcase
  end

endmodule

// File: rtl/imm_prefix_decoder.sv
// Decode-stage prefix recogniser and operand builder, registered outputs.
module imm_prefix_decoder
  import imm_prefix_pkg::*;
#(
  parameter int          WORD_W  = 16,
  parameter int          OPC_W   = 4,
  parameter int          SHORT_W = 4,
  parameter logic [3:0]  PFX_OPC = 4'hF,
  parameter logic [3:0]  LDI_OPC = 4'h1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] instr_i,
  input  logic              instr_valid_i,
  input  logic              flush_i,
  output logic              op_valid_o,
  output logic [WORD_W-1:0] operand_o,
  output logic              ext_o,
  output logic              irq_inhibit_o
);

  localparam int PAY_W = WORD_W - OPC_W;

  logic [OPC_W-1:0]  opc;
  fld_kind_t         kind;
  logic              accept;
  logic              is_pfx;
  logic              held;
  logic [PAY_W-1:0]  pay;
  logic [WORD_W-1:0] merged;

  assign opc    = instr_i[WORD_W-1 -: OPC_W];
  assign accept = instr_valid_i && !flush_i;

  always_comb begin
    if (opc == OPC_W'(PFX_OPC))      kind = FLD_PFX;
    else if (opc == OPC_W'(LDI_OPC)) kind = FLD_SHORT;
    else                             kind = FLD_NONE;
  end

  assign is_pfx = (kind == FLD_PFX);

  imm_prefix_hold #(.PAY_W(PAY_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush_i),
    .accept (accept),
    .is_pfx (is_pfx),
    .pay_in (instr_i[PAY_W-1:0]),
    .held   (held),
    .pay    (pay)
  );

  imm_prefix_merge #(
    .WORD_W  (WORD_W),
    .PAY_W   (PAY_W),
    .SHORT_W (SHORT_W)
  ) u_merge (
    .kind    (kind),
    .word    (instr_i),
    .held    (held),
    .pay     (pay),
    .operand (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid_o <= 1'b0;
      operand_o  <= '0;
      ext_o      <= 1'b0;
    end else begin
      op_valid_o <= accept && !is_pfx;
      ext_o      <= accept && !is_pfx && held;
      operand_o  <= (accept && !is_pfx) ? merged : '0;
    end
  end

  // The hold flag is itself a register, so it drives the inhibit directly
  assign irq_inhibit_o = held;

endmodule

// File: rtl/imm_prefix_decoder_chk.sv
module imm_prefix_decoder_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] instr_i,
  input logic              instr_valid_i,
  input logic              flush_i,
  input logic              op_valid_o,
  input logic [WORD_W-1:0] operand_o,
  input logic              ext_o,
  input logic              irq_inhibit_o
);

  // R2
  pfx_no_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid_i && !flush_i && instr_i[15:12] == 4'hF) |=> (!op_valid_o && irq_inhibit_o));

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (!op_valid_o && !irq_inhibit_o));

  // R7
  consumed_release_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid_o |-> !irq_inhibit_o);

  // R3
  short_unext_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid_i && !flush_i && instr_i[15:12] == 4'h1 && !irq_inhibit_o)
      |=> (operand_o[15:4] == 12'h000 && !ext_o));

  // R4
  short_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid_i && !flush_i && instr_i[15:12] == 4'h1) |=> (operand_o[3:0] == $past(instr_i[3:0])));

  // R5
  none_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid_o && !ext_o) |-> (operand_o[15:4] == 12'h000));

  // R10
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_inhibit_o && !instr_valid_i && !flush_i) |=> irq_inhibit_o);

  // R1
  ext_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ext_o |-> op_valid_o);

endmodule

bind imm_prefix_decoder imm_prefix_decoder_chk #(.WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .instr_i       (instr_i),
  .instr_valid_i (instr_valid_i),
  .flush_i       (flush_i),
  .op_valid_o    (op_valid_o),
  .operand_o     (operand_o),
  .ext_o         (ext_o),
  .irq_inhibit_o (irq_inhibit_o)
);

// File: tb/test_imm_prefix_decoder.sv
`timescale 1ns/1ps
module test_imm_prefix_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = 16'h0000;
  logic        valid = 1'b0;
  logic        flush = 1'b0;
  logic        op_valid;
  logic [15:0] operand;
  logic        ext;
  logic        inh;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string cur    = "R1";

  always #5 clk = ~clk;

  imm_prefix_decoder i_imm_prefix_decoder (
    .clk           (clk),
    .rst           (rst),
    .instr_i       (instr),
    .instr_valid_i (valid),
    .flush_i       (flush),
    .op_valid_o    (op_valid),
    .operand_o     (operand),
    .ext_o         (ext),
    .irq_inhibit_o (inh)
  );

  // Behavioural reference model
  bit        m_held = 0;
  bit [11:0] m_pay  = '0;
  bit        e_valid = 0, e_ext = 0, e_inh = 0;
  bit [15:0] e_op = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_held = 0; m_pay = '0;
      e_valid = 0; e_ext = 0; e_op = '0; e_inh = 0;
    end else begin
      bit acc, is_p;
      acc  = valid && !flush;
      is_p = (instr[15:12] == 4'hF);
      e_valid = acc && !is_p;
      e_ext   = e_valid && m_held;
      if (!e_valid)                 e_op = 16'h0000;
      else if (instr[15:12] == 4'h1) e_op = m_held ? {m_pay, instr[3:0]} : {12'h000, instr[3:0]};
      else                          e_op = m_held ? {{4{m_pay[11]}}, m_pay} : 16'h0000;
      if (flush)       m_held = 0;
      else if (acc) begin
        if (is_p) begin m_held = 1; m_pay = instr[11:0]; end
        else      m_held = 0;
      end
      e_inh = m_held;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check({cur, " model valid"},   {15'b0, op_valid}, {15'b0, e_valid});
      check({cur, " model ext"},     {15'b0, ext},      {15'b0, e_ext});
      check({cur, " model inhibit"}, {15'b0, inh},      {15'b0, e_inh});
      check({cur, " model operand"}, operand,           e_op);
    end
  end

  // Drive one word for one cycle, then go idle
  task automatic send(input logic [15:0] w, input logic v, input logic f);
    @(negedge clk); #1;
    instr = w; valid = v; flush = f;
    @(posedge clk); #1;
    valid = 1'b0; flush = 1'b0;
  endtask

  // Wait to the sampling point of the outputs produced by the last word
  task automatic settle();
    @(negedge clk); #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    idle(3);
    #2;
    check("R1 valid", {15'b0, op_valid}, 16'h0);
    check("R1 operand", operand, 16'h0);
    check("R1 inhibit", {15'b0, inh}, 16'h0);
    @(negedge clk); rst = 1'b0;
    settle();
    check("R1 ext after reset", {15'b0, ext}, 16'h0);

    cur = "R3";
    send(16'h1A37, 1, 0); settle();
    check("R3 operand", operand, 16'h0007);
    check("R3 ext", {15'b0, ext}, 16'h0);

    cur = "R2";
    send(16'hF999, 0, 0); send(16'h1004, 1, 0); settle();
    check("R2 ignored invalid prefix", operand, 16'h0004);
    send(16'hFABC, 1, 0); settle();
    check("R2 no operand", {15'b0, op_valid}, 16'h0);
    check("R10 inhibit held", {15'b0, inh}, 16'h1);

    cur = "R4";
    send(16'h1005, 1, 0); settle();
    check("R4 operand", operand, 16'hABC5);
    check("R4 ext", {15'b0, ext}, 16'h1);
    check("R7 released", {15'b0, inh}, 16'h0);

    cur = "R7";
    send(16'h1009, 1, 0); settle();
    check("R7 next not extended", operand, 16'h0009);

    cur = "R5";
    send(16'h2345, 1, 0); settle();
    check("R5 zero-width operand", operand, 16'h0000);
    check("R5 valid", {15'b0, op_valid}, 16'h1);

    cur = "R6";
    send(16'hF7FF, 1, 0); send(16'h2012, 1, 0); settle();
    check("R6 +2047", operand, 16'h07FF);
    send(16'hF800, 1, 0); send(16'h3021, 1, 0); settle();
    check("R6 -2048", operand, 16'hF800);
    send(16'hFFFF, 1, 0); send(16'h3077, 1, 0); settle();
    check("R6 -1", operand, 16'hFFFF);
    check("R6 ext", {15'b0, ext}, 16'h1);

    cur = "R8";
    send(16'hF123, 1, 0); send(16'hF456, 1, 0); send(16'h100A, 1, 0); settle();
    check("R8 second payload", operand, 16'h456A);

    cur = "R7";
    send(16'hF321, 1, 0); idle(4); send(16'h100B, 1, 0); settle();
    check("R7 held across gaps", operand, 16'h321B);
    // back-to-back prefix and target
    @(negedge clk); #1; instr = 16'hF0F0; valid = 1;
    @(posedge clk); #1; instr = 16'h1001;
    @(posedge clk); #1; valid = 0;
    settle();
    check("R7 back-to-back", operand, 16'h0F01);

    cur = "R9";
    send(16'hF555, 1, 0); send(16'h1003, 1, 1); settle();
    check("R9 flush cancels valid", {15'b0, op_valid}, 16'h0);
    check("R9 flush drops prefix", {15'b0, inh}, 16'h0);
    send(16'h1003, 1, 0); settle();
    check("R9 after flush", operand, 16'h0003);
    send(16'hF111, 1, 1); settle();
    check("R9 prefix with flush", {15'b0, inh}, 16'h0);
    send(16'h2000, 1, 0); settle();
    check("R9 no stale ext", {15'b0, ext}, 16'h0);

    cur = "R10";
    idle(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule